// File: doc/BRIEF.md
# Speculative Undo Log

This block keeps the undo information for one chunk of speculatively executed memory traffic. The first time a chunk modifies a memory location, the surrounding logic appends one entry to the log. The entry holds the location's address, the index of the timestamp-table slot that was claimed for it, and the value the location held before the chunk began. Later accesses to a location that is already logged do not produce an append. The newest value always lives in data memory, so nothing is copied while the chunk runs.

At the end of the chunk a single command selects one of two actions. Commit walks the log oldest-first, spending five cycles on each entry, and zeroes each referenced timestamp slot through a clear strobe. Data memory is left untouched. Rollback walks the log newest-first, spending eleven cycles on each entry. For each entry it writes the saved value back to its address and clears the slot in the same cycle. When the walk ends, a one-cycle done pulse marks that the log is empty again and that the table holds only zero timestamps.

The log has a fixed depth. An append that arrives when the log is full is dropped and raises a sticky overflow flag, which the owner treats as a reason to abort the chunk.

Top module: `spec_undo_log`

## Requirements
- R1: After synchronous reset, busy, walk_done, overflow, mem_we and tbl_clr are all low and the log holds no entries.
- R2: An append (app_valid high) is stored as a new entry only in a cycle where busy is low and cmd_valid is low. An append in any other cycle is dropped and never appears in a later walk.
- R3: An append that arrives while the log already holds DEPTH entries is dropped and sets overflow from the next cycle. Overflow stays high until the end of the next walk and is low in the cycle walk_done is high.
- R4: A command (cmd_valid high, cmd_rollback 1 for rollback and 0 for commit) is accepted in a cycle where busy is low. busy is high from the cycle after acceptance until walk_done.
- R5: Commit produces exactly one tbl_clr pulse per entry, oldest entry first, with tbl_clr_idx set to that entry's table index. The pulse for the j-th visited entry (j from 1) appears 5*j cycles after the accepting clock edge, and mem_we stays low throughout.
- R6: Rollback visits entries newest first. For the j-th visited entry, 11*j cycles after the accepting edge, mem_we and tbl_clr are high together for one cycle, carrying the saved address, saved data and table index.
- R7: walk_done is a single-cycle pulse. With N logged entries it appears N*5 (commit) or N*11 (rollback) cycles after the accepting edge, or 1 cycle after it when N is 0. busy is low while walk_done is high.
- R8: After walk_done the log is empty, so an immediately following command visits no entries.
- R9: A command that arrives while busy is high is ignored and does not change the running walk's order or its cycle count.
- R10: mem_we and tbl_clr are never high on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| app_valid | input | 1 | First-touch append request |
| app_addr | input | ADDR_W | Address of the touched location |
| app_idx | input | IDX_W | Timestamp-table slot claimed for it |
| app_data | input | DATA_W | Value before the chunk modified it |
| cmd_valid | input | 1 | End-of-chunk command strobe |
| cmd_rollback | input | 1 | 1 = rollback, 0 = commit |
| busy | output | 1 | A walk is in progress |
| overflow | output | 1 | An append was dropped because the log was full |
| mem_we | output | 1 | Data memory restore write enable |
| mem_addr | output | ADDR_W | Restore address |
| mem_wdata | output | DATA_W | Restored value |
| tbl_clr | output | 1 | Zero both timestamps of a table slot |
| tbl_clr_idx | output | IDX_W | Slot to zero |
| walk_done | output | 1 | One-cycle pulse at the end of a walk |

## Verification
The bench measures each restore write and clear strobe against the exact cycle where it should fall after the command. A sequencer with the wrong slot length, or one that walks rollback in insertion order, would show up as shifted cycles or as writes that carry the wrong address and data. It fills the log past its depth to confirm that the extra entry is never replayed and that the overflow flag clears only when the walk ends. It also sends appends and a second command in the middle of a walk, and an append in the same cycle as a command, then runs an empty walk afterwards. A design that let any of these through would show extra clears or a changed cycle count.

// File: rtl/undo_log_pkg.sv
package undo_log_pkg;
  // Cycles spent on each log entry during a walk
  localparam int unsigned COMMIT_CYC   = 5;
  localparam int unsigned ROLLBACK_CYC = 11;
  localparam int unsigned PH_W         = 4;

  typedef enum logic {
    WS_IDLE = 1'b0,
    WS_WALK = 1'b1
  } walk_state_t;

  function automatic logic [PH_W-1:0] slot_last(input logic rb);
    return rb ? PH_W'(ROLLBACK_CYC - 1) : PH_W'(COMMIT_CYC - 1);
  endfunction
endpackage

// File: rtl/undo_log_ram.sv
module undo_log_ram #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem_q [DEPTH];

  // Simple dual-port, registered read: maps onto block RAM
  always_ff @(posedge clk) begin
    if (we) mem_q[waddr] <= wdata;
    rdata <= mem_q[raddr];
  end
endmodule

// File: rtl/undo_log_ptr.sv
module undo_log_ptr #(
  parameter int DEPTH = 8,
  localparam int PW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          app_valid,
  input  logic          cmd_valid,
  input  logic          busy,
  input  logic          clear,
  output logic          wr_en,
  output logic [PW-1:0] wr_ptr,
  output logic [CW-1:0] count,
  output logic          overflow
);
  logic accept, full;

  assign accept = app_valid && !busy && !cmd_valid;
  assign full   = (count == CW'(DEPTH));
  assign wr_en  = accept && !full;
  assign wr_ptr = PW'(count);

  always_ff @(posedge clk) begin
    if (rst) begin
      count    <= '0;
      overflow <= 1'b0;
    end else if (clear) begin
      count    <= '0;
      overflow <= 1'b0;
    end else begin
      if (wr_en) count <= count + 1'b1;
      if (accept && full) overflow <= 1'b1;
    end
  end

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));
  // R2
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !clear) |=> $stable(count));
  // R3
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (overflow && !clear) |=> overflow);
endmodule

// File: rtl/undo_walk_seq.sv
module undo_walk_seq
  import undo_log_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 10,
  parameter int IDX_W  = 6,
  parameter int DATA_W = 16,
  localparam int PW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1),
  localparam int EW = ADDR_W + IDX_W + DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic              cmd_rollback,
  input  logic [CW-1:0]     count,
  input  logic [EW-1:0]     rd_word,
  output logic [PW-1:0]     rd_ptr,
  output logic              busy,
  output logic              finish,
  output logic              done,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              tbl_clr,
  output logic [IDX_W-1:0]  tbl_idx
);
  walk_state_t     state_q;
  logic            rb_q;
  logic [PW-1:0]   cur_q;
  logic [CW-1:0]   left_q;
  logic [PH_W-1:0] ph_q;
  logic            slot_end, last_entry;

  logic [ADDR_W-1:0] ent_addr;
  logic [IDX_W-1:0]  ent_idx;
  logic [DATA_W-1:0] ent_data;

  assign ent_addr = rd_word[EW-1 -: ADDR_W];
  assign ent_idx  = rd_word[DATA_W +: IDX_W];
  assign ent_data = rd_word[DATA_W-1:0];

  assign rd_ptr     = cur_q;
  assign busy       = (state_q == WS_WALK);
  assign slot_end   = busy && (ph_q == slot_last(rb_q));
  assign last_entry = (left_q == CW'(1));
  assign finish     = (!busy && cmd_valid && count == '0) || (slot_end && last_entry);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= WS_IDLE;
      rb_q      <= 1'b0;
      cur_q     <= '0;
      left_q    <= '0;
      ph_q      <= '0;
      done      <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      tbl_clr   <= 1'b0;
      tbl_idx   <= '0;
    end else begin
      done    <= 1'b0;
      mem_we  <= 1'b0;
      tbl_clr <= 1'b0;
      if (!busy) begin
        if (cmd_valid) begin
          if (count == '0) begin
            done <= 1'b1;
          end else begin
            state_q <= WS_WALK;
            rb_q    <= cmd_rollback;
            cur_q   <= cmd_rollback ? PW'(count - 1'b1) : '0;
            left_q  <= count;
            ph_q    <= '0;
          end
        end
      end else if (slot_end) begin
        ph_q    <= '0;
        tbl_clr <= 1'b1;
        tbl_idx <= ent_idx;
        if (rb_q) begin
          mem_we    <= 1'b1;
          mem_addr  <= ent_addr;
          mem_wdata <= ent_data;
        end
        if (last_entry) begin
          state_q <= WS_IDLE;
          done    <= 1'b1;
        end else begin
          left_q <= left_q - 1'b1;
          cur_q  <= rb_q ? cur_q - 1'b1 : cur_q + 1'b1;
        end
      end else begin
        ph_q <= ph_q + 1'b1;
      end
    end
  end

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  // R6
  restore_pair_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> tbl_clr);
  // R10
  clr_gap_chk: assert property (@(posedge clk) disable iff (rst)
    tbl_clr |=> !tbl_clr);
  // R5
  phase_range_chk: assert property (@(posedge clk) disable iff (rst)
    ph_q <= PH_W'(ROLLBACK_CYC - 1));
endmodule

// File: rtl/spec_undo_log.sv
module spec_undo_log #(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 10,
  parameter int IDX_W  = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              app_valid,
  input  logic [ADDR_W-1:0] app_addr,
  input  logic [IDX_W-1:0]  app_idx,
  input  logic [DATA_W-1:0] app_data,
  input  logic              cmd_valid,
  input  logic              cmd_rollback,
  output logic              busy,
  output logic              overflow,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              tbl_clr,
  output logic [IDX_W-1:0]  tbl_clr_idx,
  output logic              walk_done
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int EW = ADDR_W + IDX_W + DATA_W;

  logic          wr_en, finish;
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic [EW-1:0] rd_word;

  undo_log_ptr #(.DEPTH(DEPTH)) u_ptr (
    .clk(clk), .rst(rst), .app_valid(app_valid), .cmd_valid(cmd_valid),
    .busy(busy), .clear(finish), .wr_en(wr_en), .wr_ptr(wr_ptr),
    .count(count), .overflow(overflow)
  );

  undo_log_ram #(.WIDTH(EW), .DEPTH(DEPTH)) u_ram (
    .clk(clk), .we(wr_en), .waddr(wr_ptr),
    .wdata({app_addr, app_idx, app_data}),
    .raddr(rd_ptr), .rdata(rd_word)
  );

  undo_walk_seq #(
    .DEPTH(DEPTH), .ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W)
  ) u_seq (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_rollback(cmd_rollback),
    .count(count), .rd_word(rd_word), .rd_ptr(rd_ptr), .busy(busy),
    .finish(finish), .done(walk_done), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .tbl_clr(tbl_clr), .tbl_idx(tbl_clr_idx)
  );

  // R8
  empty_after_done_chk: assert property (@(posedge clk) disable iff (rst)
    walk_done |-> (count == '0));
  // R3
  ovf_clear_chk: assert property (@(posedge clk) disable iff (rst)
    walk_done |-> !overflow);
endmodule

// File: tb/spec_undo_log_tb.sv
module spec_undo_log_tb_top;
  localparam int DEPTH  = 8;
  localparam int ADDR_W = 10;
  localparam int IDX_W  = 6;
  localparam int DATA_W = 16;
  localparam int N_SCN  = 6;
  // {rollback, entry count}
  localparam logic [4:0] SCN [N_SCN] = '{5'h03, 5'h13, 5'h01, 5'h18, 5'h11, 5'h08};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic app_valid = 1'b0;
  logic [ADDR_W-1:0] app_addr = '0;
  logic [IDX_W-1:0]  app_idx = '0;
  logic [DATA_W-1:0] app_data = '0;
  logic cmd_valid = 1'b0, cmd_rollback = 1'b0;
  logic busy, overflow, mem_we, tbl_clr, walk_done;
  logic [ADDR_W-1:0] mem_addr;
  logic [DATA_W-1:0] mem_wdata;
  logic [IDX_W-1:0]  tbl_clr_idx;

  always #4 clk = ~clk;

  spec_undo_log #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) dut_i (
    .clk(clk), .rst(rst), .app_valid(app_valid), .app_addr(app_addr),
    .app_idx(app_idx), .app_data(app_data), .cmd_valid(cmd_valid),
    .cmd_rollback(cmd_rollback), .busy(busy), .overflow(overflow),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .tbl_clr(tbl_clr), .tbl_clr_idx(tbl_clr_idx), .walk_done(walk_done)
  );

  int total = 0, bad = 0;
  int ecount = 0, cmd_e0 = 0;
  int w_addr [256], w_data [256], w_t [256], c_idx [256], c_t [256];
  int n_w = 0, n_c = 0, done_cnt = 0, done_t = 0;
  int e_addr [16], e_idx [16], e_data [16];
  int n_exp = 0;

  always @(posedge clk) begin
    ecount <= ecount + 1;
    if (!rst && cmd_valid && !busy) cmd_e0 <= ecount;
  end

  always @(negedge clk) begin
    if (!rst) begin
      if (mem_we) begin
        w_addr[n_w] = int'(mem_addr); w_data[n_w] = int'(mem_wdata); w_t[n_w] = ecount;
        n_w = n_w + 1;
      end
      if (tbl_clr) begin
        c_idx[n_c] = int'(tbl_clr_idx); c_t[n_c] = ecount;
        n_c = n_c + 1;
      end
      if (walk_done) begin
        done_t = ecount;
        done_cnt = done_cnt + 1;
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic push(input int a, input int i, input int d, input bit keep);
    app_valid = 1'b1;
    app_addr = ADDR_W'(a); app_idx = IDX_W'(i); app_data = DATA_W'(d);
    if (keep) begin
      e_addr[n_exp] = a; e_idx[n_exp] = i; e_data[n_exp] = d;
      n_exp++;
    end
    @(negedge clk);
    app_valid = 1'b0;
  endtask

  task automatic issue(input bit rb);
    cmd_valid = 1'b1; cmd_rollback = rb;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_done(input int d0);
    while (done_cnt == d0) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic walk_and_check(input bit rb, input int n);
    int w0, c0, d0, slot, k;
    w0 = n_w; c0 = n_c; d0 = done_cnt; slot = rb ? 11 : 5;
    issue(rb);
    wait_done(d0);
    chk("R7 done cycle", done_t, cmd_e0 + n * slot + 1);
    chk("R7 busy low after done", int'(busy), 0);
    chk(rb ? "R6 clear count" : "R5 clear count", n_c - c0, n);
    chk(rb ? "R6 write count" : "R5 no mem write", n_w - w0, rb ? n : 0);
    for (int j = 0; j < n && c0 + j < n_c; j++) begin
      k = rb ? n - 1 - j : j;
      chk(rb ? "R6 clear idx" : "R5 clear idx", c_idx[c0 + j], e_idx[k]);
      chk(rb ? "R6 clear cycle" : "R5 clear cycle", c_t[c0 + j], cmd_e0 + (j + 1) * slot + 1);
      if (rb && w0 + j < n_w) begin
        chk("R6 restore addr", w_addr[w0 + j], e_addr[k]);
        chk("R6 restore data", w_data[w0 + j], e_data[k]);
        chk("R6 write with clear", w_t[w0 + j], c_t[c0 + j]);
      end
    end
    n_exp = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int c0, d0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy", int'(busy), 0);
    chk("R1 done", int'(walk_done), 0);
    chk("R1 overflow", int'(overflow), 0);
    chk("R1 mem_we", int'(mem_we), 0);
    chk("R1 tbl_clr", int'(tbl_clr), 0);
    walk_and_check(1'b0, 0);   // R1 empty log after reset

    // Table-driven walks
    for (int s = 0; s < N_SCN; s++) begin
      for (int j = 0; j < int'(SCN[s][3:0]); j++)
        push((s * 37 + j * 13 + 5) % 1024, (s * 5 + j * 7) % 64,
             (16'hA000 ^ (s << 8) ^ (j * 257)) & 16'hFFFF, 1'b1);
      walk_and_check(SCN[s][4], int'(SCN[s][3:0]));
    end

    // R3 overflow: ninth append dropped, flag clears on done
    for (int j = 0; j < DEPTH + 1; j++)
      push(100 + j, 40 + j, 16'h5000 + j, j < DEPTH);
    chk("R3 overflow set", int'(overflow), 1);
    walk_and_check(1'b1, DEPTH);
    chk("R3 overflow cleared", int'(overflow), 0);

    // R9 / R2 / R4: append and command during a walk
    push(7, 3, 16'h1111, 1'b1);
    push(9, 4, 16'h2222, 1'b1);
    c0 = n_c; d0 = done_cnt;
    issue(1'b0);
    chk("R4 busy during walk", int'(busy), 1);
    push(11, 5, 16'h3333, 1'b0);
    issue(1'b1);
    wait_done(d0);
    chk("R9 cycle count unchanged", done_t, cmd_e0 + 2 * 5 + 1);
    chk("R9 clear count", n_c - c0, 2);
    chk("R9 first clear idx", c_idx[c0], 3);
    n_exp = 0;
    c0 = n_c;
    walk_and_check(1'b1, 0);   // R8 log empty after walk
    chk("R2 busy append dropped", n_c - c0, 0);

    // R2: append in same cycle as command is dropped
    d0 = done_cnt;
    app_valid = 1'b1; app_addr = 10'd50; app_idx = 6'd9; app_data = 16'h4444;
    cmd_valid = 1'b1; cmd_rollback = 1'b1;
    @(negedge clk);
    app_valid = 1'b0; cmd_valid = 1'b0;
    wait_done(d0);
    c0 = n_c;
    walk_and_check(1'b1, 0);
    chk("R2 same-cycle append dropped", n_c - c0, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule